// File: doc/BRIEF.md
# Dual-Bus Masked Match Event Counter

This block watches two parallel data buses and keeps three running event counts. Each bus is compared on every sampled cycle with its own programmable pattern under its own care mask. Bits whose mask bit is 0 are don't-care. One counter tallies matches on the first bus, a second tallies matches on the second bus, and a third tallies the sampled cycles where both buses match together.

Pattern and mask constants are loaded through a simple one-cycle register write port. Each count sits in a feedback register that an incrementer updates. A counter stops at all-ones and does not wrap. A synchronous clear input zeroes all three counts. The block suits on-chip debug, for example counting how often a transaction of a given shape appears on a bus.

Top module: `twin_bus_match_tally`

## Requirements
- R1: After the asynchronous reset `rst_n` has been asserted, all three counts read 0 and every pattern and care mask register holds 0. The counts stay 0 until the first sampled cycle after release.
- R2: A bus matches when ((bus XOR pattern) AND care_mask) is all zeros. A care_mask bit of 1 makes that bit significant, and a bit of 0 makes it don't-care.
- R3: On a clock edge where `sample_vld` is 1 and `bus_a` matches, `cnt_a` increases by exactly one. It is visible after that edge.
- R4: On a clock edge where `sample_vld` is 1 and `bus_b` matches, `cnt_b` increases by exactly one.
- R5: On a clock edge where `sample_vld` is 1 and both buses match, `cnt_both` increases by exactly one. `cnt_both` never exceeds `cnt_a` or `cnt_b`.
- R6: While `sample_vld` is 0, no count changes, whatever the bus values are.
- R7: Each count saturates at all-ones (16'hFFFF at default width) and holds there on further matches.
- R8: `cnt_clear` = 1 at a clock edge sets all three counts to 0. It takes priority over a match in the same cycle.
- R9: A write with `cfg_we` = 1 loads `cfg_wdata` into the register that `cfg_addr` selects: 0 = pattern A, 1 = mask A, 2 = pattern B, 3 = mask B. The new value applies to samples taken after the write edge. A sample taken in the same cycle as the write uses the old value. A write never changes a count.
- R10: With the reset-default all-zero care masks, every sampled cycle counts as a match on both buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_clear | input | 1 | Synchronous clear of all three counts |
| sample_vld | input | 1 | Bus values in this cycle are to be compared |
| bus_a | input | BUS_W | First monitored bus |
| bus_b | input | BUS_W | Second monitored bus |
| cfg_we | input | 1 | Write strobe for pattern and mask registers |
| cfg_addr | input | 2 | Register select (0 pat A, 1 mask A, 2 pat B, 3 mask B) |
| cfg_wdata | input | BUS_W | Write data |
| cnt_a | output | CNT_W | Match count of bus A |
| cnt_b | output | CNT_W | Match count of bus B |
| cnt_both | output | CNT_W | Count of cycles with both buses matching |

## Verification
The comparison is tried with patterns where each bus differs from its pattern only in masked-out bits (which must match), only in cared bits (which must not), or in both. Each bus is set up with a different mask, so one mixed-up mask or pattern register shows as a wrong count on one bus. The vectors mix cycles where A alone, B alone, both or neither match. That separates the coincidence count from the per-bus counts and shows the effect of the valid strobe. Directed cases cover a write in the same cycle as a sample, a clear that coincides with a match, and a run of more than 65535 matches that reaches saturation.

// File: rtl/mtally_pkg.sv
package mtally_pkg;

  localparam int NUM_BUS = 2;

  typedef enum logic [1:0] {
    CFG_PAT_A  = 2'd0,
    CFG_MASK_A = 2'd1,
    CFG_PAT_B  = 2'd2,
    CFG_MASK_B = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/mtally_rst_sync.sv
module mtally_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mtally_cfg_regs.sv
module mtally_cfg_regs
  import mtally_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [1:0]                       addr,
  input  logic [BUS_W-1:0]                 wdata,
  output logic [NUM_BUS-1:0][BUS_W-1:0]    pat,
  output logic [NUM_BUS-1:0][BUS_W-1:0]    mask
);

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(addr);

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    localparam cfg_sel_e PAT_SEL  = (g == 0) ? CFG_PAT_A  : CFG_PAT_B;
    localparam cfg_sel_e MASK_SEL = (g == 0) ? CFG_MASK_A : CFG_MASK_B;

    logic             pat_en;
    logic             mask_en;
    logic [BUS_W-1:0] pat_q;
    logic [BUS_W-1:0] mask_q;

    always_comb begin
      pat_en  = we && (sel == PAT_SEL);
      mask_en = we && (sel == MASK_SEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_q <= '0;
      end else if (pat_en) begin
        pat_q <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
      end else if (mask_en) begin
        mask_q <= wdata;
      end
    end

    assign pat[g]  = pat_q;
    assign mask[g] = mask_q;
  end

endmodule

// File: rtl/mtally_matcher.sv
module mtally_matcher #(
  parameter int BUS_W = 16
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] pat,
  input  logic [BUS_W-1:0] care,
  output logic             hit
);

  logic [BUS_W-1:0] diff;

  always_comb begin
    diff = (bus ^ pat) & care;
    hit  = (diff == '0);
  end

endmodule

// File: rtl/mtally_sat_counter.sv
module mtally_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc && (cnt_q != MAX_VAL)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/twin_bus_match_tally.sv
module twin_bus_match_tally
  import mtally_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clear,
  input  logic             sample_vld,
  input  logic [BUS_W-1:0] bus_a,
  input  logic [BUS_W-1:0] bus_b,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [BUS_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic [CNT_W-1:0] cnt_both
);

  logic                          rst_int_n;
  logic [NUM_BUS-1:0][BUS_W-1:0] bus_vec;
  logic [NUM_BUS-1:0][BUS_W-1:0] pat_vec;
  logic [NUM_BUS-1:0][BUS_W-1:0] mask_vec;
  logic [NUM_BUS-1:0]            hit;
  logic [NUM_BUS-1:0][CNT_W-1:0] cnt_vec;
  logic                          both_inc;

  mtally_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mtally_cfg_regs #(.BUS_W(BUS_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .pat   (pat_vec),
    .mask  (mask_vec)
  );

  assign bus_vec = {bus_b, bus_a};

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
    mtally_matcher #(.BUS_W(BUS_W)) u_match (
      .bus  (bus_vec[g]),
      .pat  (pat_vec[g]),
      .care (mask_vec[g]),
      .hit  (hit[g])
    );

    mtally_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (cnt_clear),
      .inc   (sample_vld & hit[g]),
      .count (cnt_vec[g])
    );
  end

  assign both_inc = sample_vld & (&hit);

  mtally_sat_counter #(.CNT_W(CNT_W)) u_cnt_both (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cnt_clear),
    .inc   (both_inc),
    .count (cnt_both)
  );

  assign cnt_a = cnt_vec[0];
  assign cnt_b = cnt_vec[1];

endmodule

// File: rtl/mtally_checker.sv
module mtally_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_clear,
  input logic             sample_vld,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic [CNT_W-1:0] cnt_both
);

  localparam logic [CNT_W-1:0] TOP = '1;

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !cnt_clear) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_both)));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (cnt_a == '0 && cnt_b == '0 && cnt_both == '0));

  p_step_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (cnt_a == $past(cnt_a) || cnt_a == CNT_W'($past(cnt_a) + 1'b1)));

  p_step_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (cnt_b == $past(cnt_b) || cnt_b == CNT_W'($past(cnt_b) + 1'b1)));

  p_both_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_both <= cnt_a) && (cnt_both <= cnt_b));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a == TOP && !cnt_clear) |=> (cnt_a == TOP));

endmodule

bind twin_bus_match_tally mtally_checker #(.CNT_W(CNT_W)) u_mtally_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_clear  (cnt_clear),
  .sample_vld (sample_vld),
  .cnt_a      (cnt_a),
  .cnt_b      (cnt_b),
  .cnt_both   (cnt_both)
);

// File: tb/test_twin_bus_match_tally.sv
`timescale 1ns/1ps
module test_twin_bus_match_tally;

  localparam int BUS_W = 16;
  localparam int CNT_W = 16;
  localparam int NVEC  = 8;

  // {bus_a, bus_b, valid, expect A hit, expect B hit}
  // A setup: pattern A5C3, mask FF00 -> hit iff bus_a[15:8] == A5
  // B setup: pattern 1234, mask 0FF0 -> hit iff bus_b[11:4] == 23
  localparam logic [34:0] VEC [NVEC] = '{
    {16'hA5FF, 16'h0230, 1'b1, 1'b1, 1'b1},
    {16'hA500, 16'hF23F, 1'b1, 1'b1, 1'b1},
    {16'hA400, 16'h1234, 1'b1, 1'b0, 1'b1},
    {16'hA5C3, 16'h1244, 1'b1, 1'b1, 1'b0},
    {16'h25C3, 16'h1334, 1'b1, 1'b0, 1'b0},
    {16'hA5C3, 16'h1234, 1'b0, 1'b1, 1'b1},
    {16'hFFFF, 16'h0235, 1'b1, 1'b0, 1'b1},
    {16'hA512, 16'h9999, 1'b1, 1'b1, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cnt_clear;
  logic             sample_vld;
  logic [BUS_W-1:0] bus_a;
  logic [BUS_W-1:0] bus_b;
  logic             cfg_we;
  logic [1:0]       cfg_addr;
  logic [BUS_W-1:0] cfg_wdata;
  logic [CNT_W-1:0] cnt_a;
  logic [CNT_W-1:0] cnt_b;
  logic [CNT_W-1:0] cnt_both;

  int n_chk  = 0;
  int n_fail = 0;
  int ea = 0;
  int eb = 0;
  int ec = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  twin_bus_match_tally #(.BUS_W(BUS_W), .CNT_W(CNT_W)) i_twin_bus_match_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_clear  (cnt_clear),
    .sample_vld (sample_vld),
    .bus_a      (bus_a),
    .bus_b      (bus_b),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b),
    .cnt_both   (cnt_both)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " cnt_a"},    int'(cnt_a),    ea);
    check({req, " cnt_b"},    int'(cnt_b),    eb);
    check({req, " cnt_both"}, int'(cnt_both), ec);
  endtask

  // one clock edge; return at the following falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [BUS_W-1:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    cycle();
    cfg_we    = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; cnt_clear = 1'b0; sample_vld = 1'b0;
    bus_a = '0; bus_b = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) cycle();
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) cycle();
    check_all("R1 after release");

    // R10: default masks are zero, so anything matches
    bus_a = 16'h1357; bus_b = 16'h9BDF; sample_vld = 1'b1;
    cycle();
    sample_vld = 1'b0;
    ea++; eb++; ec++;
    check_all("R10 default match");

    // R9: configure through the four addresses; counts untouched
    wr(2'd0, 16'hA5C3);
    wr(2'd1, 16'hFF00);
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'h0FF0);
    check_all("R9 write keeps counts");

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [34:0] v;
      v = VEC[i];
      bus_a = v[34:19]; bus_b = v[18:3]; sample_vld = v[2];
      cycle();
      if (v[2]) begin
        ea += int'(v[1]);
        eb += int'(v[0]);
        ec += int'(v[1] & v[0]);
      end
      check_all($sformatf("R2/R3/R4/R5/R6 vec%0d", i));
    end

    // R9: sample in the write cycle uses old mask
    bus_a = 16'hA500; bus_b = 16'h0000; sample_vld = 1'b1;
    wr(2'd1, 16'hFFFF);
    ea++;
    check_all("R9 same-cycle old mask");
    cycle();
    check_all("R9 new mask applies");

    // R6: idle strobe with matching buses
    sample_vld = 1'b0; bus_a = 16'hA5C3; bus_b = 16'h1234;
    repeat (3) cycle();
    check_all("R6 idle");

    // R8: clear beats a simultaneous match
    wr(2'd1, 16'hFF00);
    sample_vld = 1'b1; cnt_clear = 1'b1;
    cycle();
    cnt_clear = 1'b0;
    ea = 0; eb = 0; ec = 0;
    check_all("R8 clear wins");
    cycle();
    ea = 1; eb = 1; ec = 1;
    check_all("R8 counting resumes");

    // R7: saturation
    sample_vld = 1'b0;
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0000);
    sample_vld = 1'b1;
    repeat (65540) cycle();
    ea = 16'hFFFF; eb = 16'hFFFF; ec = 16'hFFFF;
    check_all("R7 saturated");
    cycle();
    check_all("R7 holds at max");
    sample_vld = 1'b0; cnt_clear = 1'b1;
    cycle();
    cnt_clear = 1'b0;
    ea = 0; eb = 0; ec = 0;
    check_all("R8 clear from max");

    done = 1'b1;
    report();
  end

endmodule